// File: doc/BRIEF.md
# Shadowed Working RAM with Bulk Store/Recall Engine

This block is a synchronous byte-wide working RAM paired with a nonvolatile shadow array of equal depth. The shadow array is modelled as a second register array. The host reads and writes only the working RAM, through chip-enable, write-enable and output-enable controls. On request, a copy engine moves the whole memory in one direction or the other:

- A **store** first erases every shadow location to all ones, then programs each one from the working RAM.
- A **recall** first clears every working location to zero, then loads each one from the shadow array. It never modifies the shadow.

A busy flag covers each copy. While busy is high, host accesses are dropped and the data output reads as high-impedance. The supply-good input has two roles. It blocks and cancels stores. Its first rise after reset launches an automatic recall, and the host stays locked out until that recall finishes.

The host port is a plain synchronous port, not a stream. It has no ready signal and applies no back-pressure: an access presented while busy is high is simply lost. Read data is registered and appears one cycle after the access. The output-valid flag plays the role of an output driver, and data reads as zero whenever it is low. The store and recall requests are single-cycle control pulses.

Top module: `nvshadow_ram`

## Requirements
- R1: A cycle with `ce`=1, `we`=0 and busy low reads the word at `addr`. After that clock edge, `dout` carries the word and `dout_valid` equals the `oe` sampled at the edge. Whenever `dout_valid` is 0, `dout` is 0.
- R2: A cycle with `ce`=1, `we`=1 and busy low writes `din` to `addr`. After that edge, `dout_valid` is 0 even if `oe` is 1.
- R3: A cycle with `ce`=0 changes no location, and after that edge `dout_valid` is 0.
- R4: A `store_req` pulse taken while idle with `supply_good`=1 raises `busy` for exactly STORE_CYCLES clocks (at least 2×DEPTH). During that time the shadow is erased to all ones and then loaded from the working RAM; a later recall returns the stored contents.
- R5: A `recall_req` pulse taken while idle raises `busy` for exactly RECALL_CYCLES clocks (at least 2×DEPTH). The working RAM is zeroed and then loaded from the shadow. The shadow is left intact, so a second recall yields the same data.
- R6: While `busy`=1, host writes change no location and host reads leave `dout_valid` at 0.
- R7: A store is not started while `supply_good`=0, and `busy` stays 0. If `supply_good` falls during a store, `busy` is 0 after the next edge and the working RAM is unchanged. A recall runs to full length regardless of `supply_good`.
- R8: `busy` is 1 from reset until the automatic recall completes. That recall starts at the first edge with `supply_good`=1 and lasts RECALL_CYCLES clocks.
- R9: A `store_req` or `recall_req` arriving while `busy`=1 is ignored, and the busy period keeps its original length.
- R10: When `store_req` and `recall_req` are both high at an idle edge, the recall is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_good | input | 1 | Supply healthy indication |
| store_req | input | 1 | Request a bulk copy RAM to shadow |
| recall_req | input | 1 | Request a bulk copy shadow to RAM |
| ce | input | 1 | Chip enable, active high |
| we | input | 1 | Write enable, active high |
| oe | input | 1 | Output enable, active high |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not valid |
| dout_valid | output | 1 | Read data is being driven |
| busy | output | 1 | Copy engine active or power-up recall pending |

## Verification
The bench fills the whole RAM with an address-XOR pattern and stores it. It then overwrites the RAM with a second, unrelated pattern, so that reading back the first pattern after a recall can only come from the shadow and not from stale RAM. Store and recall use busy lengths that differ by a few cycles, which makes the measured length show which operation ran when both requests coincide. A targeted overwrite before recalls run with supply low, with both requests raised together, and before an abandoned store separates "recall happened" from "nothing happened". Writes and requests injected in the middle of a store show whether those inputs leaked through.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE   = 2'd0,
    ENG_STORE  = 2'd1,
    ENG_RECALL = 2'd2
  } eng_state_t;
endpackage

// File: rtl/nvs_storage.sv
module nvs_storage #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              ram_we,
  input  logic [ADDR_W-1:0] ram_wa,
  input  logic [DATA_W-1:0] ram_wd,
  input  logic [ADDR_W-1:0] ram_ra0,
  output logic [DATA_W-1:0] ram_rd0,
  input  logic [ADDR_W-1:0] ram_ra1,
  output logic [DATA_W-1:0] ram_rd1,
  input  logic              sh_we,
  input  logic [ADDR_W-1:0] sh_a,
  input  logic [DATA_W-1:0] sh_wd,
  output logic [DATA_W-1:0] sh_rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram_q [DEPTH];
  logic [DATA_W-1:0] sh_q  [DEPTH];

  always_ff @(posedge clk) begin
    if (ram_we) ram_q[ram_wa] <= ram_wd;
  end

  always_ff @(posedge clk) begin
    if (sh_we) sh_q[sh_a] <= sh_wd;
  end

  assign ram_rd0 = ram_q[ram_ra0];
  assign ram_rd1 = ram_q[ram_ra1];
  assign sh_rd   = sh_q[sh_a];
endmodule

// File: rtl/nvs_copy_engine.sv
module nvs_copy_engine
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int STORE_CYCLES  = 2 * (1 << ADDR_W),
  parameter int RECALL_CYCLES = 2 * (1 << ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_good,
  input  logic              store_req,
  input  logic              recall_req,
  input  logic [DATA_W-1:0] ram_rd,
  input  logic [DATA_W-1:0] sh_rd,
  output logic [ADDR_W-1:0] idx,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wd,
  output logic              sh_we,
  output logic [DATA_W-1:0] sh_wd,
  output logic              busy
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int MIN_LEN = 2 * DEPTH;
  localparam int ST_LEN  = (STORE_CYCLES  < MIN_LEN) ? MIN_LEN : STORE_CYCLES;
  localparam int RC_LEN  = (RECALL_CYCLES < MIN_LEN) ? MIN_LEN : RECALL_CYCLES;
  localparam int MAX_LEN = (ST_LEN > RC_LEN) ? ST_LEN : RC_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  eng_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             first_phase;
  logic             second_phase;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ENG_IDLE;
      cnt   <= '0;
      armed <= 1'b1;
    end else begin
      case (state)
        ENG_IDLE: begin
          cnt <= '0;
          if (armed) begin
            if (supply_good) begin
              state <= ENG_RECALL;
              armed <= 1'b0;
            end
          end else if (recall_req) begin
            state <= ENG_RECALL;
          end else if (store_req && supply_good) begin
            state <= ENG_STORE;
          end
        end
        ENG_STORE: begin
          if (!supply_good || cnt == CNT_W'(ST_LEN - 1)) begin
            state <= ENG_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ENG_RECALL: begin
          if (cnt == CNT_W'(RC_LEN - 1)) begin
            state <= ENG_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ENG_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign idx          = cnt[ADDR_W-1:0];
  assign first_phase  = cnt < CNT_W'(DEPTH);
  assign second_phase = !first_phase && (cnt < CNT_W'(MIN_LEN));

  always_comb begin
    sh_we  = 1'b0;
    sh_wd  = '1;
    ram_we = 1'b0;
    ram_wd = '0;
    if (state == ENG_STORE && supply_good) begin
      sh_we = first_phase || second_phase;
      sh_wd = first_phase ? '1 : ram_rd;
    end
    if (state == ENG_RECALL) begin
      ram_we = first_phase || second_phase;
      ram_wd = first_phase ? '0 : sh_rd;
    end
  end

  assign busy = (state != ENG_IDLE) || armed;
endmodule

// File: rtl/nvs_host_port.sv
module nvs_host_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              ce,
  input  logic              we,
  input  logic              oe,
  input  logic [DATA_W-1:0] ram_rd,
  output logic              host_we,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid
);
  logic rd_take;

  assign host_we = ce && we && !busy;
  assign rd_take = ce && !we && !busy && oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= rd_take;
      dout       <= rd_take ? ram_rd : '0;
    end
  end
endmodule

// File: rtl/nvshadow_ram.sv
module nvshadow_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int STORE_CYCLES  = 2 * (1 << ADDR_W) + 16,
  parameter int RECALL_CYCLES = 2 * (1 << ADDR_W) + 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_good,
  input  logic              store_req,
  input  logic              recall_req,
  input  logic              ce,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              busy
);
  logic [ADDR_W-1:0] eng_idx;
  logic              eng_ram_we, eng_sh_we, host_we;
  logic [DATA_W-1:0] eng_ram_wd, eng_sh_wd;
  logic [DATA_W-1:0] host_rd, eng_ram_rd, sh_rd;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_wa;
  logic [DATA_W-1:0] ram_wd;

  assign ram_we = eng_ram_we || host_we;
  assign ram_wa = eng_ram_we ? eng_idx : addr;
  assign ram_wd = eng_ram_we ? eng_ram_wd : din;

  nvs_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .ram_we(ram_we), .ram_wa(ram_wa), .ram_wd(ram_wd),
    .ram_ra0(addr), .ram_rd0(host_rd), .ram_ra1(eng_idx), .ram_rd1(eng_ram_rd),
    .sh_we(eng_sh_we), .sh_a(eng_idx), .sh_wd(eng_sh_wd), .sh_rd(sh_rd)
  );

  nvs_copy_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .supply_good(supply_good),
    .store_req(store_req), .recall_req(recall_req),
    .ram_rd(eng_ram_rd), .sh_rd(sh_rd), .idx(eng_idx),
    .ram_we(eng_ram_we), .ram_wd(eng_ram_wd),
    .sh_we(eng_sh_we), .sh_wd(eng_sh_wd), .busy(busy)
  );

  nvs_host_port #(.DATA_W(DATA_W)) u_host (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ce(ce), .we(we), .oe(oe),
    .ram_rd(host_rd), .host_we(host_we), .dout(dout), .dout_valid(dout_valid)
  );
endmodule

// File: rtl/nvshadow_ram_chk.sv
module nvshadow_ram_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              supply_good,
  input logic              store_req,
  input logic              recall_req,
  input logic              ce,
  input logic              we,
  input logic              oe,
  input logic [DATA_W-1:0] dout,
  input logic              dout_valid,
  input logic              busy
);
  AST_VALID_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> $past(oe)); // R1
  AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> (dout == '0)); // R1
  AST_WRITE_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && we) |=> !dout_valid); // R2
  AST_DESEL_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> !dout_valid); // R3
  AST_BUSY_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !dout_valid); // R6
  AST_STORE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && store_req && !recall_req && !supply_good) |=> !busy); // R7
endmodule

bind nvshadow_ram nvshadow_ram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .store_req(store_req),
  .recall_req(recall_req), .ce(ce), .we(we), .oe(oe), .dout(dout),
  .dout_valid(dout_valid), .busy(busy)
);

// File: tb/nvshadow_ram_tb_top.sv
module nvshadow_ram_tb_top;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int ST_LEN = 2 * DEPTH + 16;
  localparam int RC_LEN = 2 * DEPTH + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_good = 1'b0, store_req = 1'b0, recall_req = 1'b0;
  logic ce = 1'b0, we = 1'b0, oe = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_valid, busy;
  int cyc = 0;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvshadow_ram #(.ADDR_W(AW), .DATA_W(DW), .STORE_CYCLES(ST_LEN),
                 .RECALL_CYCLES(RC_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_good(supply_good), .store_req(store_req),
    .recall_req(recall_req), .ce(ce), .we(we), .oe(oe), .addr(addr), .din(din),
    .dout(dout), .dout_valid(dout_valid), .busy(busy));

  function automatic logic [DW-1:0] pat1(int a); return DW'(a) ^ 8'h5A; endfunction
  function automatic logic [DW-1:0] pat2(int a); return ~DW'(a) + 8'd3; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d, input bit o);
    @(negedge clk); ce = 1; we = 1; oe = o; addr = AW'(a); din = d;
    @(posedge clk); #1; ce = 0; we = 0; oe = 0;
  endtask

  task automatic rd(input int a, input bit o, input bit c,
                    output logic [DW-1:0] d, output logic v);
    @(negedge clk); ce = c; we = 0; oe = o; addr = AW'(a);
    @(posedge clk); #1; d = dout; v = dout_valid; ce = 0; oe = 0;
  endtask

  task automatic pulse(input bit s, input bit r, output int start);
    @(negedge clk); store_req = s; recall_req = r;
    @(posedge clk); #1; start = cyc; store_req = 0; recall_req = 0;
  endtask

  task automatic wait_idle(output int stop);
    while (busy) begin @(posedge clk); #1; end
    stop = cyc;
  endtask

  task automatic sweep(input string req, input bit use_p1);
    logic [DW-1:0] d; logic v; int bad = -1; logic [DW-1:0] e, got = '0;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, 1, 1, d, v);
      e = use_p1 ? pat1(a) : pat2(a);
      if ((!v || d != e) && bad < 0) begin bad = a; got = d; end
    end
    check(bad < 0, req, int'(got), bad < 0 ? 0 : int'(use_p1 ? pat1(bad) : pat2(bad)));
  endtask

  task automatic t_reset_powerup();
    int s, e;
    rst_n = 0; repeat (3) @(posedge clk); #1; rst_n = 1;
    repeat (5) @(posedge clk); #1;
    check(busy == 1, "R8 busy before supply", busy, 1);
    check(dout_valid == 0, "R1 valid at reset", dout_valid, 0);
    @(negedge clk); supply_good = 1;
    @(posedge clk); #1; s = cyc;
    wait_idle(e);
    check(e - s == RC_LEN, "R8 power-up recall length", e - s, RC_LEN);
  endtask

  task automatic t_host_rw();
    logic [DW-1:0] d; logic v;
    for (int a = 0; a < DEPTH; a++) wr(a, pat1(a), 0);
    sweep("R1/R2 readback p1", 1);
    rd(DEPTH - 1, 0, 1, d, v);
    check(v == 0 && d == 0, "R1 read with oe low", {v, d}, 0);
    @(negedge clk); ce = 1; we = 1; oe = 1; addr = 5; din = pat1(5);
    @(posedge clk); #1; ce = 0; we = 0; oe = 0;
    check(dout_valid == 0, "R2 valid during write", dout_valid, 0);
    @(negedge clk); ce = 0; we = 1; oe = 1; addr = 6; din = 8'hC3;
    @(posedge clk); #1; we = 0; oe = 0;
    check(dout_valid == 0, "R3 deselected valid", dout_valid, 0);
    rd(6, 1, 1, d, v);
    check(v && d == pat1(6), "R3 deselected write ignored", d, pat1(6));
  endtask

  task automatic t_store_recall();
    int s, e;
    pulse(1, 0, s); wait_idle(e);
    check(e - s == ST_LEN, "R4 store length", e - s, ST_LEN);
    for (int a = 0; a < DEPTH; a++) wr(a, pat2(a), 0);
    sweep("R2 readback p2", 0);
    pulse(0, 1, s); wait_idle(e);
    check(e - s == RC_LEN, "R5 recall length", e - s, RC_LEN);
    sweep("R4/R5 recalled data", 1);
    for (int a = 0; a < DEPTH; a++) wr(a, pat2(a), 0);
    pulse(0, 1, s); wait_idle(e);
    sweep("R5 shadow unchanged by recall", 1);
  endtask

  task automatic t_busy_ignore();
    int s, e; logic [DW-1:0] d; logic v;
    pulse(1, 0, s);
    repeat (3) @(posedge clk); #1;
    wr(7, 8'hA5, 1);
    rd(8, 1, 1, d, v);
    check(v == 0, "R6 read while busy", v, 0);
    pulse(0, 1, e);
    pulse(1, 0, e);
    wait_idle(e);
    check(e - s == ST_LEN, "R9 requests while busy ignored", e - s, ST_LEN);
    rd(7, 1, 1, d, v);
    check(v && d == pat1(7), "R6 write while busy ignored", d, pat1(7));
  endtask

  task automatic t_supply_low();
    int s, e; logic [DW-1:0] d; logic v;
    @(negedge clk); supply_good = 0;
    pulse(1, 0, s);
    check(busy == 0, "R7 store blocked by supply", busy, 0);
    wr(9, 8'hEE, 0);
    pulse(0, 1, s); wait_idle(e);
    check(e - s == RC_LEN, "R7 recall with supply low", e - s, RC_LEN);
    rd(9, 1, 1, d, v);
    check(v && d == pat1(9), "R7 recall data with supply low", d, pat1(9));
    @(negedge clk); supply_good = 1;
  endtask

  task automatic t_priority();
    int s, e; logic [DW-1:0] d; logic v;
    wr(9, 8'hEE, 0);
    pulse(1, 1, s); wait_idle(e);
    check(e - s == RC_LEN, "R10 recall wins length", e - s, RC_LEN);
    rd(9, 1, 1, d, v);
    check(v && d == pat1(9), "R10 recall wins data", d, pat1(9));
  endtask

  task automatic t_abort();
    int s; logic [DW-1:0] d; logic v;
    wr(11, 8'h33, 0);
    pulse(1, 0, s);
    repeat (20) @(posedge clk);
    @(negedge clk); supply_good = 0;
    @(posedge clk); #1;
    check(busy == 0, "R7 store abandoned", busy, 0);
    rd(11, 1, 1, d, v);
    check(v && d == 8'h33, "R7 RAM kept after abort", d, 8'h33);
    rd(0, 1, 1, d, v);
    check(v && d == pat1(0), "R7 RAM kept after abort addr 0", d, pat1(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    t_reset_powerup();
    t_host_rw();
    t_store_recall();
    t_busy_ignore();
    t_supply_low();
    t_priority();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule